// File: doc/BRIEF.md
# DMA Descriptor Configuration Error Checker

This block examines a DMA transfer descriptor before a channel begins working on it, and it also records bus faults that occur while data is moving. When a descriptor is loaded, the block checks a fixed set of rules against the source and destination transfer sizes:

- source address alignment;
- source offset granularity;
- destination address alignment;
- destination offset granularity;
- minor-loop byte count granularity;
- a zero current iteration count;
- mismatched link-enable bits on the current and beginning iteration counts.

When a major loop completes with scatter/gather enabled, the block checks that the address of the next descriptor is on a 32-byte boundary. Source-read and destination-write bus error strobes each set their own status bit.

The block keeps only the most recent error. A new error writes a fresh status word, and that word holds every failing bit found in that cycle. The block also latches the channel that caused the error and raises a valid flag. The valid flag stays set until the clear strobe arrives.

Only the low five bits of each address-like field affect any rule, so only those bits enter the block.

Top module: `dma_desc_err_chk`

## Requirements
- R1: Transfer sizes are encoded 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 16 bytes. A descriptor load whose two's-complement source offset is not a multiple of the source size sets status bit 6.
- R2: A descriptor load whose destination address is not a multiple of the destination size sets status bit 5. The size encoding is the one given in R1.
- R3: A descriptor load whose two's-complement destination offset is not a multiple of the destination size sets status bit 4.
- R4: A descriptor load sets status bit 3 under any of three conditions: the minor-loop byte count is not a multiple of both sizes, the current iteration count is zero, or the current and beginning link-enable bits differ.
- R5: A descriptor load whose source address is not a multiple of the source size sets status bit 7.
- R6: Status bit 2 is set only by a major-loop completion strobe while scatter/gather is enabled, and only when the next-descriptor address has any of its low five bits set. A descriptor load never evaluates this rule.
- R7: A source-read bus error strobe sets status bit 1. A destination-write bus error strobe sets status bit 0.
- R8: An input strobe sampled at one rising edge updates the status on the following rising edge. A sampled cycle in which no rule fails leaves the status, the channel and the valid flag unchanged.
- R9: An update replaces the whole status word. Its bits are the OR of every failing bit from all strobes sampled in that same cycle.
- R10: Every update latches the channel number that was sampled together with the failing strobe.
- R11: An update sets the valid flag. The valid flag stays set until a clear strobe is sampled. A clear leaves the status and the channel unchanged. When a clear and an update fall on the same edge, the valid flag stays set.
- R12: A synchronous active-high reset clears the status, the channel and the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_stb | input | 1 | Descriptor load strobe |
| major_done_stb | input | 1 | Major-loop completion strobe |
| src_bus_err | input | 1 | Bus error on a source read |
| dst_bus_err | input | 1 | Bus error on a destination write |
| clr_err | input | 1 | Clears the valid flag |
| chan_in | input | CH_W | Channel that owns the current strobe |
| src_addr_lo | input | 5 | Low bits of the source address |
| src_offs_lo | input | 5 | Low bits of the signed source offset |
| dst_addr_lo | input | 5 | Low bits of the destination address |
| dst_offs_lo | input | 5 | Low bits of the signed destination offset |
| src_size | input | 2 | Source transfer size code |
| dst_size | input | 2 | Destination transfer size code |
| nbytes_lo | input | 5 | Low bits of the minor-loop byte count |
| citer | input | CIT_W | Current iteration count |
| citer_link | input | 1 | Link enable of the current count |
| biter_link | input | 1 | Link enable of the beginning count |
| sga_lo | input | 5 | Low bits of the next-descriptor address |
| sga_en | input | 1 | Scatter/gather enable |
| err_status | output | 8 | Status word of the last recorded error |
| err_chan | output | CH_W | Channel of the last recorded error |
| err_valid | output | 1 | An error has been recorded and not cleared |

## Verification
A wrong captured field or a wrong rule mask changes err_status on the second rising edge after the strobe. That change is therefore visible one cycle after the capture stage should have taken it. A stale capture flag or a broken update-enable either invents an update in a quiet cycle or drops a real one. The cycle-by-cycle reference model catches both at that same edge through err_status, err_chan or err_valid. A fault in the valid logic shows up on the edge that follows a clear strobe, or on the edge that follows a quiet cycle while an error is held.

// File: rtl/dma_desc_err_pkg.sv
package dma_desc_err_pkg;

   localparam int LO_W = 5;
   localparam int ST_W = 8;

   localparam int BIT_DBE = 0;
   localparam int BIT_SBE = 1;
   localparam int BIT_SGE = 2;
   localparam int BIT_NCE = 3;
   localparam int BIT_DOE = 4;
   localparam int BIT_DAE = 5;
   localparam int BIT_SOE = 6;
   localparam int BIT_SAE = 7;

   typedef enum logic [1:0] {
      SZ_1B  = 2'd0,
      SZ_2B  = 2'd1,
      SZ_4B  = 2'd2,
      SZ_BLK = 2'd3
   } xfer_size_e;

   typedef struct packed {
      logic [LO_W-1:0] src_addr;
      logic [LO_W-1:0] src_offs;
      logic [LO_W-1:0] dst_addr;
      logic [LO_W-1:0] dst_offs;
      logic [1:0]      src_size;
      logic [1:0]      dst_size;
      logic [LO_W-1:0] nbytes;
      logic            citer_zero;
      logic            link_diff;
      logic [LO_W-1:0] sga;
   } desc_cap_t;

endpackage

// File: rtl/dma_size_mask.sv
module dma_size_mask
   import dma_desc_err_pkg::*;
#(
   parameter bit BLK_IS_32 = 1'b0
) (
   input  logic [1:0]      size,
   output logic [LO_W-1:0] mask
);

   logic [LO_W-1:0] blk_mask;

   generate
      if (BLK_IS_32) begin : g_blk32
         assign blk_mask = 5'h1F;
      end else begin : g_blk16
         assign blk_mask = 5'h0F;
      end
   endgenerate

   always_comb begin
      case (xfer_size_e'(size))
         SZ_1B:   mask = 5'h00;
         SZ_2B:   mask = 5'h01;
         SZ_4B:   mask = 5'h03;
         default: mask = blk_mask;
      endcase
   end

endmodule

// File: rtl/dma_cfg_rules.sv
module dma_cfg_rules
   import dma_desc_err_pkg::*;
#(
   parameter bit BLK_IS_32 = 1'b0
) (
   input  desc_cap_t       cap,
   output logic [ST_W-1:0] cfg_bits
);

   logic [LO_W-1:0] s_mask;
   logic [LO_W-1:0] d_mask;

   dma_size_mask #(.BLK_IS_32(BLK_IS_32)) u_smask (
      .size (cap.src_size),
      .mask (s_mask)
   );

   dma_size_mask #(.BLK_IS_32(BLK_IS_32)) u_dmask (
      .size (cap.dst_size),
      .mask (d_mask)
   );

   always_comb begin
      cfg_bits          = '0;
      cfg_bits[BIT_SAE] = |(cap.src_addr & s_mask);
      cfg_bits[BIT_SOE] = |(cap.src_offs & s_mask);
      cfg_bits[BIT_DAE] = |(cap.dst_addr & d_mask);
      cfg_bits[BIT_DOE] = |(cap.dst_offs & d_mask);
      cfg_bits[BIT_NCE] = (|(cap.nbytes & (s_mask | d_mask)))
                          | cap.citer_zero | cap.link_diff;
   end

endmodule

// File: rtl/dma_err_status.sv
module dma_err_status
   import dma_desc_err_pkg::*;
#(
   parameter int CH_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [ST_W-1:0] upd_bits,
   input  logic [CH_W-1:0] upd_chan,
   input  logic            clr,
   output logic [ST_W-1:0] status,
   output logic [CH_W-1:0] chan,
   output logic            valid
);

   logic upd;
   assign upd = |upd_bits;

   always_ff @(posedge clk) begin
      if (rst) begin
         status <= '0;
         chan   <= '0;
         valid  <= 1'b0;
      end else if (upd) begin
         status <= upd_bits;
         chan   <= upd_chan;
         valid  <= 1'b1;
      end else if (clr) begin
         valid  <= 1'b0;
      end
   end

endmodule

// File: rtl/dma_desc_err_chk.sv
module dma_desc_err_chk
   import dma_desc_err_pkg::*;
#(
   parameter int CH_W      = 4,
   parameter int CIT_W     = 15,
   parameter bit BLK_IS_32 = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load_stb,
   input  logic            major_done_stb,
   input  logic            src_bus_err,
   input  logic            dst_bus_err,
   input  logic            clr_err,
   input  logic [CH_W-1:0] chan_in,
   input  logic [LO_W-1:0] src_addr_lo,
   input  logic [LO_W-1:0] src_offs_lo,
   input  logic [LO_W-1:0] dst_addr_lo,
   input  logic [LO_W-1:0] dst_offs_lo,
   input  logic [1:0]      src_size,
   input  logic [1:0]      dst_size,
   input  logic [LO_W-1:0] nbytes_lo,
   input  logic [CIT_W-1:0] citer,
   input  logic            citer_link,
   input  logic            biter_link,
   input  logic [LO_W-1:0] sga_lo,
   input  logic            sga_en,
   output logic [ST_W-1:0] err_status,
   output logic [CH_W-1:0] err_chan,
   output logic            err_valid
);

   generate
      if (CH_W < 1) begin : g_bad_ch
         $error("CH_W must be at least 1");
      end
      if (CIT_W < 1) begin : g_bad_cit
         $error("CIT_W must be at least 1");
      end
   endgenerate

   desc_cap_t       cap;
   logic            cap_load;
   logic            cap_sg;
   logic            cap_sbe;
   logic            cap_dbe;
   logic [CH_W-1:0] cap_chan;
   logic [ST_W-1:0] cfg_bits;
   logic [ST_W-1:0] upd_bits;

   always_ff @(posedge clk) begin
      if (rst) begin
         cap      <= '0;
         cap_load <= 1'b0;
         cap_sg   <= 1'b0;
         cap_sbe  <= 1'b0;
         cap_dbe  <= 1'b0;
         cap_chan <= '0;
      end else begin
         cap_load       <= load_stb;
         cap_sg         <= major_done_stb & sga_en;
         cap_sbe        <= src_bus_err;
         cap_dbe        <= dst_bus_err;
         cap_chan       <= chan_in;
         cap.src_addr   <= src_addr_lo;
         cap.src_offs   <= src_offs_lo;
         cap.dst_addr   <= dst_addr_lo;
         cap.dst_offs   <= dst_offs_lo;
         cap.src_size   <= src_size;
         cap.dst_size   <= dst_size;
         cap.nbytes     <= nbytes_lo;
         cap.citer_zero <= (citer == '0);
         cap.link_diff  <= citer_link ^ biter_link;
         cap.sga        <= sga_lo;
      end
   end

   dma_cfg_rules #(.BLK_IS_32(BLK_IS_32)) u_rules (
      .cap      (cap),
      .cfg_bits (cfg_bits)
   );

   always_comb begin
      upd_bits          = cap_load ? cfg_bits : '0;
      upd_bits[BIT_SGE] = cap_sg & (|cap.sga);
      upd_bits[BIT_SBE] = cap_sbe;
      upd_bits[BIT_DBE] = cap_dbe;
   end

   dma_err_status #(.CH_W(CH_W)) u_status (
      .clk      (clk),
      .rst      (rst),
      .upd_bits (upd_bits),
      .upd_chan (cap_chan),
      .clr      (clr_err),
      .status   (err_status),
      .chan     (err_chan),
      .valid    (err_valid)
   );

endmodule

// File: rtl/dma_desc_err_chk_sva.sv
module dma_desc_err_chk_sva
   import dma_desc_err_pkg::*;
(
   input logic            clk,
   input logic            rst,
   input logic            load_stb,
   input logic            major_done_stb,
   input logic            src_bus_err,
   input logic            dst_bus_err,
   input logic            clr_err,
   input logic [LO_W-1:0] dst_addr_lo,
   input logic [1:0]      dst_size,
   input logic [ST_W-1:0] err_status,
   input logic            err_valid
);

   logic ev;
   assign ev = load_stb | major_done_stb | src_bus_err | dst_bus_err;

   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !ev |=> ##1 $stable(err_status)); // R8

   AST_SBE_ALONE: assert property (@(posedge clk) disable iff (rst)
      (src_bus_err && !load_stb && !major_done_stb && !dst_bus_err)
      |=> ##1 (err_status == 8'h02)); // R7

   AST_DAE_WORD: assert property (@(posedge clk) disable iff (rst)
      (load_stb && dst_size == 2'd2 && dst_addr_lo[1:0] != 2'd0)
      |=> ##1 err_status[BIT_DAE]); // R2

   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
      (clr_err && !$past(ev)) |=> !err_valid); // R11

   AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
      (err_valid && !clr_err) |=> err_valid); // R11

   AST_ROSE_NONZERO: assert property (@(posedge clk) disable iff (rst)
      $rose(err_valid) |-> (err_status != '0)); // R9

endmodule

bind dma_desc_err_chk dma_desc_err_chk_sva u_sva (
   .clk            (clk),
   .rst            (rst),
   .load_stb       (load_stb),
   .major_done_stb (major_done_stb),
   .src_bus_err    (src_bus_err),
   .dst_bus_err    (dst_bus_err),
   .clr_err        (clr_err),
   .dst_addr_lo    (dst_addr_lo),
   .dst_size       (dst_size),
   .err_status     (err_status),
   .err_valid      (err_valid)
);

// File: tb/tb_dma_desc_err_chk.sv
`timescale 1ns/1ps
module tb_dma_desc_err_chk;

   localparam int CH_W  = 4;
   localparam int CIT_W = 15;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic load_stb = 0, major_done_stb = 0, src_bus_err = 0, dst_bus_err = 0, clr_err = 0;
   logic [CH_W-1:0] chan_in = '0;
   logic [1:0] src_size = 2'd2, dst_size = 2'd2;
   logic citer_link = 0, biter_link = 0, sga_en = 0;
   int s_addr = 32'h100, s_off = 4, d_addr = 32'h200, d_off = 4;
   int nb = 16, cit = 5, sga = 32'h40;

   logic [4:0] src_addr_lo, src_offs_lo, dst_addr_lo, dst_offs_lo, nbytes_lo, sga_lo;
   logic [CIT_W-1:0] citer;
   logic [7:0] err_status;
   logic [CH_W-1:0] err_chan;
   logic err_valid;

   assign src_addr_lo = s_addr[4:0];
   assign src_offs_lo = s_off[4:0];
   assign dst_addr_lo = d_addr[4:0];
   assign dst_offs_lo = d_off[4:0];
   assign nbytes_lo   = nb[4:0];
   assign sga_lo      = sga[4:0];
   assign citer       = cit[CIT_W-1:0];

   always #5 clk = ~clk;

   dma_desc_err_chk #(.CH_W(CH_W), .CIT_W(CIT_W)) dut (
      .clk(clk), .rst(rst), .load_stb(load_stb), .major_done_stb(major_done_stb),
      .src_bus_err(src_bus_err), .dst_bus_err(dst_bus_err), .clr_err(clr_err),
      .chan_in(chan_in), .src_addr_lo(src_addr_lo), .src_offs_lo(src_offs_lo),
      .dst_addr_lo(dst_addr_lo), .dst_offs_lo(dst_offs_lo), .src_size(src_size),
      .dst_size(dst_size), .nbytes_lo(nbytes_lo), .citer(citer),
      .citer_link(citer_link), .biter_link(biter_link), .sga_lo(sga_lo),
      .sga_en(sga_en), .err_status(err_status), .err_chan(err_chan),
      .err_valid(err_valid)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   function automatic int nbytes_of(input logic [1:0] sz);
      return (sz == 2'd3) ? 16 : (1 << sz);
   endfunction

   // behavioural reference model
   int m_st = 0, m_ch = 0, m_v = 0;
   int p_bits = 0, p_ch = 0;

   always @(posedge clk) begin
      int b;
      int sb;
      int db;
      if (rst) begin
         m_st = 0; m_ch = 0; m_v = 0; p_bits = 0; p_ch = 0;
      end else begin
         if (p_bits != 0) begin
            m_st = p_bits; m_ch = p_ch; m_v = 1;
         end else if (clr_err) begin
            m_v = 0;
         end
         sb = nbytes_of(src_size);
         db = nbytes_of(dst_size);
         b = 0;
         if (load_stb) begin
            if (s_addr % sb != 0) b += 128;
            if (s_off % sb != 0)  b += 64;
            if (d_addr % db != 0) b += 32;
            if (d_off % db != 0)  b += 16;
            if ((nb % sb != 0) || (nb % db != 0) || (cit == 0) || (citer_link != biter_link))
               b += 8;
         end
         if (major_done_stb && sga_en && (sga % 32 != 0)) b += 4;
         if (src_bus_err) b += 2;
         if (dst_bus_err) b += 1;
         p_bits = b;
         p_ch = int'(chan_in);
      end
   end

   always @(posedge clk) begin
      #2;
      chk("R8 model status", int'(err_status), m_st);
      chk("R10 model channel", int'(err_chan), m_ch);
      chk("R11 model valid", int'(err_valid), m_v);
   end

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
   end

   // pulse strobes for one cycle, return after the update edge
   task automatic pulse(input bit ld, input bit mj, input bit sbe, input bit dbe);
      @(negedge clk);
      load_stb = ld; major_done_stb = mj; src_bus_err = sbe; dst_bus_err = dbe;
      @(negedge clk);
      load_stb = 0; major_done_stb = 0; src_bus_err = 0; dst_bus_err = 0;
      @(negedge clk);
   endtask

   task automatic clear();
      @(negedge clk); clr_err = 1;
      @(negedge clk); clr_err = 0;
   endtask

   task automatic good();
      s_addr = 32'h100; s_off = 4; d_addr = 32'h200; d_off = 4;
      src_size = 2'd2; dst_size = 2'd2; nb = 16; cit = 5;
      citer_link = 0; biter_link = 0; sga = 32'h40; sga_en = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      chk("R12 reset status", int'(err_status), 0);
      chk("R12 reset channel", int'(err_chan), 0);
      chk("R12 reset valid", int'(err_valid), 0);

      chan_in = 3; pulse(1, 0, 0, 0);
      chk("R8 clean load no valid", int'(err_valid), 0);
      chk("R8 clean load status", int'(err_status), 0);

      s_off = 2; pulse(1, 0, 0, 0);
      chk("R1 source offset bit6", int'(err_status), 8'h40);
      chk("R11 valid set", int'(err_valid), 1);
      chk("R10 channel 3", int'(err_chan), 3);

      s_off = -4; chan_in = 5; pulse(1, 0, 0, 0);
      chk("R1 negative aligned offset no change", int'(err_status), 8'h40);
      chk("R8 no update keeps channel", int'(err_chan), 3);
      s_off = -6; chan_in = 6; pulse(1, 0, 0, 0);
      chk("R1 negative misaligned offset", int'(err_status), 8'h40);
      chk("R10 channel 6", int'(err_chan), 6);
      good();

      d_addr = 32'h202; pulse(1, 0, 0, 0);
      chk("R2 dest address bit5", int'(err_status), 8'h20);
      good(); dst_size = 2'd3; d_off = 16; nb = 32; d_addr = 32'h208; pulse(1, 0, 0, 0);
      chk("R2 dest address 16-byte", int'(err_status), 8'h20);
      clear(); d_addr = 32'h210; pulse(1, 0, 0, 0);
      chk("R2 16-byte aligned no error", int'(err_valid), 0);
      good();

      d_off = 6; pulse(1, 0, 0, 0);
      chk("R3 dest offset bit4", int'(err_status), 8'h10);
      good(); clear();

      nb = 6; pulse(1, 0, 0, 0);
      chk("R4 byte count bit3", int'(err_status), 8'h08);
      good(); clear(); cit = 0; pulse(1, 0, 0, 0);
      chk("R4 zero iteration", int'(err_status), 8'h08);
      chk("R4 zero iteration valid", int'(err_valid), 1);
      good(); clear(); citer_link = 1; pulse(1, 0, 0, 0);
      chk("R4 link mismatch", int'(err_status), 8'h08);
      good();

      s_addr = 32'h101; chan_in = 9; pulse(1, 0, 0, 0);
      chk("R5 source address bit7", int'(err_status), 8'h80);
      chk("R10 channel 9", int'(err_chan), 9);
      good();

      s_off = 2; d_off = 6; pulse(1, 0, 0, 0);
      chk("R9 combined bits", int'(err_status), 8'h50);
      good();

      sga_en = 1; sga = 32'h50; pulse(0, 1, 0, 0);
      chk("R6 scatter gather bit2", int'(err_status), 8'h04);
      clear(); sga_en = 0; pulse(0, 1, 0, 0);
      chk("R6 disabled no error", int'(err_valid), 0);
      sga_en = 1; pulse(1, 0, 0, 0);
      chk("R6 not checked on load", int'(err_valid), 0);
      sga = 32'h60; pulse(0, 1, 0, 0);
      chk("R6 aligned next descriptor", int'(err_valid), 0);
      good();

      pulse(0, 0, 1, 0);
      chk("R7 source bus bit1", int'(err_status), 8'h02);
      pulse(0, 0, 0, 1);
      chk("R9 replaced by dest bus bit0", int'(err_status), 8'h01);
      pulse(0, 0, 1, 1);
      chk("R7 both bus bits", int'(err_status), 8'h03);

      clear(); @(negedge clk);
      chk("R11 clear drops valid", int'(err_valid), 0);
      chk("R11 clear keeps status", int'(err_status), 8'h03);

      @(negedge clk); src_bus_err = 1;
      @(negedge clk); src_bus_err = 0; clr_err = 1;
      @(negedge clk); clr_err = 0;
      chk("R11 update wins over clear", int'(err_valid), 1);

      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      chk("R12 reset clears status", int'(err_status), 0);
      chk("R12 reset clears valid", int'(err_valid), 0);

      repeat (3) @(negedge clk);
      finish_up();
   end

endmodule